// File: doc/BRIEF.md
# 100 Mb/s PCS Transmit Encoder

This block takes 4-bit transmit nibbles from a media-independent-style interface and turns them into a serial line stream. It uses one bit-rate clock. An internal modulo-5 counter divides that clock into nibble periods, and the output `nib_tick` marks the cycle in which the nibble inputs are sampled. Each sampled nibble becomes one 5-bit code group. A frame starts when `tx_en` rises. Its first two nibbles are replaced by the start delimiter groups /J/ and /K/. The rest of the frame goes through the 4B/5B data table unchanged. When `tx_en` falls, the end delimiter groups /T/ and /R/ are appended. IDLE groups fill every slot that no frame occupies.

The code groups are shifted out most significant bit first, one bit per clock, and then NRZI encoded. A collision flag reports simultaneous transmit and receive activity when the link runs half duplex. In full duplex the flag stays low.

Top module: `pcs100_tx_encoder`

## Requirements
- R1: After reset `nrzi_out` is 0, `col` is 0 and `nib_tick` is 0, and the first code groups sent are IDLE.
- R2: Whenever no frame or delimiter is being sent, the IDLE group 11111 is sent.
- R3: The first two nibble slots of a frame are sent as /J/ = 11000 and then /K/ = 10001, whatever their nibble values.
- R4: Every later nibble of the frame is sent as its 4B/5B group: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: In the first nibble slot where `tx_en` is low after a frame's data, /T/ = 01101 is sent. /R/ = 00111 follows, and then IDLE.
- R6: If `tx_en` falls during either of the first two slots of a frame, the block still sends /J/ /K/, then /T/ /R/, then IDLE.
- R7: `tx_en` and `txd` are sampled on the rising edge where `nib_tick` is high. `nib_tick` is high for one cycle in every five. Each group is sent over the next five clocks, bit 4 first.
- R8: `nrzi_out` toggles for each code bit 1 and holds its level for each code bit 0.
- R9: With `full_duplex` low, `col` is high on the clock after one in which `tx_en` and `rx_active` are both high. Otherwise `col` is low on that clock.
- R10: With `full_duplex` high, `col` stays low whatever `tx_en` and `rx_active` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble |
| rx_active | input | 1 | Receive activity on the medium |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| nib_tick | output | 1 | High in the cycle whose rising edge samples the nibble inputs |
| nrzi_out | output | 1 | Serial NRZI line bit |
| col | output | 1 | Collision indication |

## Verification
The hardest case to reach is a frame cut short while the delimiter is still going out. Here `tx_en` falls in the slot that gets /K/, and the framer must still finish /J/K/ before /T/R/. The stimulus places each nibble exactly one nibble period apart by waiting for `nib_tick`, so it can drop `tx_en` after one or after two slots. The line output is checked by recovering the code groups: the bench XORs consecutive NRZI levels and cuts the bits into groups at the tick boundaries.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    typedef logic [CG_W-1:0]  cg_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SEND_K,
        FS_DATA,
        FS_SEND_R
    } fstate_e;

    function automatic cg_t map_nibble(input nib_t n);
        cg_t g;
        unique case (n)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
    import pcs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_en,
    input  nib_t txd,
    output cg_t  cg_next
);
    typedef struct packed {
        fstate_e st;
        cg_t     cg;
    } frm_t;

    frm_t    d, q;
    fstate_e st_n;
    cg_t     grp;

    always_comb begin
        d    = q;
        st_n = q.st;
        grp  = CG_IDLE;
        unique case (q.st)
            FS_IDLE: begin
                if (tx_en) begin
                    grp  = CG_J;
                    st_n = FS_SEND_K;
                end
            end
            FS_SEND_K: begin
                grp  = CG_K;
                st_n = FS_DATA;
            end
            FS_DATA: begin
                if (tx_en) begin
                    grp = map_nibble(txd);
                end else begin
                    grp  = CG_T;
                    st_n = FS_SEND_R;
                end
            end
            default: begin
                grp  = CG_R;
                st_n = FS_IDLE;
            end
        endcase
        if (tick) begin
            d.st = st_n;
            d.cg = grp;
        end
    end

    assign cg_next = grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FS_IDLE, cg: CG_IDLE};
        end else begin
            q <= d;
        end
    end

    assert_k_follows_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.cg == CG_J) |-> (cg_next == CG_K));

    assert_r_follows_t_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.cg == CG_T) |-> (cg_next == CG_R));

    assert_after_r_idle_or_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.cg == CG_R) |-> (cg_next == CG_IDLE || cg_next == CG_J));

    assert_no_k_without_j_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cg_next == CG_K) |-> (q.cg == CG_J));
endmodule

// File: rtl/pcs_tx_serializer.sv
module pcs_tx_serializer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_val,
    output logic         tick,
    output logic         nrzi
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
        logic             lvl;
    } ser_t;

    ser_t d, q;
    logic cur_bit;

    assign cur_bit = q.sh[W-1];
    assign tick    = (q.cnt == LAST);
    assign nrzi    = q.lvl;

    always_comb begin
        d     = q;
        d.lvl = q.lvl ^ cur_bit;
        if (q.cnt == LAST) begin
            d.cnt = '0;
            d.sh  = load_val;
        end else begin
            d.cnt = q.cnt + 1'b1;
            d.sh  = {q.sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, sh: '1, lvl: 1'b0};
        end else begin
            q <= d;
        end
    end

    assert_counter_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_toggle_on_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bit |=> (nrzi != $past(nrzi)));

    assert_hold_on_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_bit |=> $stable(nrzi));
endmodule

// File: rtl/pcs_tx_collision.sv
module pcs_tx_collision (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_active,
    input  logic full_duplex,
    output logic col
);
    typedef struct packed {
        logic col;
    } colst_t;

    colst_t d, q;

    always_comb begin
        d     = q;
        d.col = !full_duplex && tx_en && rx_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{col: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign col = q.col;

    assert_full_duplex_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !col);

    assert_col_needs_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_active) |=> !col);
endmodule

// File: rtl/pcs100_tx_encoder.sv
module pcs100_tx_encoder
    import pcs_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             rx_active,
    input  logic             full_duplex,
    output logic             nib_tick,
    output logic             nrzi_out,
    output logic             col
);
    cg_t  next_group;
    logic tick;

    pcs_tx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tx_en   (tx_en),
        .txd     (txd),
        .cg_next (next_group)
    );

    pcs_tx_serializer #(.W(CG_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (next_group),
        .tick     (tick),
        .nrzi     (nrzi_out)
    );

    pcs_tx_collision u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .rx_active   (rx_active),
        .full_duplex (full_duplex),
        .col         (col)
    );

    assign nib_tick = tick;

    assert_idle_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && next_group != CG_IDLE) |-> (tx_en || u_framer.q.st != FS_IDLE));
endmodule

// File: tb/pcs100_tx_encoder_test.sv
module pcs100_tx_encoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       rx_active = 1'b0;
    logic       full_duplex = 1'b0;
    logic       nib_tick;
    logic       nrzi_out;
    logic       col;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    localparam logic [4:0] IDLE_G = 5'b11111;
    localparam logic [4:0] J_G = 5'b11000;
    localparam logic [4:0] K_G = 5'b10001;
    localparam logic [4:0] T_G = 5'b01101;
    localparam logic [4:0] R_G = 5'b00111;

    logic [4:0] tbl [16];
    logic [3:0] fr [0:47];
    logic [4:0] cap [0:511];
    int         cap_n = 0;
    logic       prev_lvl = 1'b0;
    logic       tick_prev = 1'b0;
    logic [4:0] sr = '0;
    logic       bitv;

    always #10 clk = ~clk;

    pcs100_tx_encoder uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
        .rx_active(rx_active), .full_duplex(full_duplex),
        .nib_tick(nib_tick), .nrzi_out(nrzi_out), .col(col)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            bitv = nrzi_out ^ prev_lvl;
            prev_lvl = nrzi_out;
            sr = {sr[3:0], bitv};
            if (tick_prev && cap_n < 512) begin
                cap[cap_n] = sr;
                cap_n = cap_n + 1;
            end
            tick_prev = nib_tick;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        nchecks++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic en, input logic [3:0] d);
        @(negedge clk);
        while (!nib_tick) @(negedge clk);
        tx_en = en;
        txd = d;
    endtask

    task automatic clear_cap();
        @(negedge clk);
        #1 cap_n = 0;
    endtask

    task automatic check_stream(input string req_tag, input int n);
        logic [4:0] ex [0:63];
        int m = 0;
        int k = -1;
        int idle_ok = 1;
        ex[m] = J_G; m = m + 1;
        ex[m] = K_G; m = m + 1;
        for (int i = 2; i < n; i++) begin
            ex[m] = tbl[fr[i]];
            m = m + 1;
        end
        ex[m] = T_G; m = m + 1;
        ex[m] = R_G; m = m + 1;
        ex[m] = IDLE_G; m = m + 1;
        ex[m] = IDLE_G; m = m + 1;
        for (int i = 0; i < cap_n; i++) begin
            if (k < 0 && cap[i] != IDLE_G) k = i;
        end
        chk("R3", "frame start found", int'(k >= 0), 1);
        if (k >= 0) begin
            for (int i = 0; i < k; i++) if (cap[i] != IDLE_G) idle_ok = 0;
            chk("R2", "idle before frame", idle_ok, 1);
            for (int j = 0; j < m; j++) begin
                if (k + j < cap_n) begin
                    if (j < 2) chk(req_tag.len() > 0 ? req_tag : "R3", "delimiter", int'(cap[k+j]), int'(ex[j]));
                    else if (j < n) chk("R4", "data group", int'(cap[k+j]), int'(ex[j]));
                    else chk(req_tag.len() > 0 ? req_tag : "R5", "end/idle", int'(cap[k+j]), int'(ex[j]));
                end else begin
                    chk("R7", "group captured", 0, 1);
                end
            end
        end
    endtask

    task automatic test_reset();
        chk("R1", "nrzi at reset", int'(nrzi_out), 0);
        chk("R1", "col at reset", int'(col), 0);
        chk("R1", "tick at reset", int'(nib_tick), 0);
        @(negedge clk);
        #2 rst_n = 1'b1;
        repeat (6) send(1'b0, 4'h0);
        chk("R1", "groups after reset", cap_n > 3 ? 1 : 0, 1);
        for (int i = 0; i < cap_n; i++) chk("R1", "idle after reset", int'(cap[i]), int'(IDLE_G));
    endtask

    task automatic test_tick_period();
        int gap = 0;
        @(negedge clk);
        while (!nib_tick) @(negedge clk);
        @(negedge clk);
        gap = 1;
        while (!nib_tick) begin
            @(negedge clk);
            gap++;
        end
        chk("R7", "tick period", gap, 5);
    endtask

    task automatic test_idle_toggle();
        logic last;
        int toggles = 0;
        @(negedge clk);
        last = nrzi_out;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (nrzi_out != last) toggles++;
            last = nrzi_out;
        end
        chk("R8", "idle toggles every bit", toggles, 10);
    endtask

    task automatic test_full_frame();
        int n = 0;
        for (int i = 0; i < 15; i++) begin fr[n] = 4'h5; n++; end
        fr[n] = 4'hD; n++;
        for (int i = 0; i < 16; i++) begin fr[n] = 4'(i); n++; end
        fr[n] = 4'h0; n++;
        fr[n] = 4'h0; n++;
        clear_cap();
        for (int i = 0; i < n; i++) send(1'b1, fr[i]);
        repeat (8) send(1'b0, 4'h0);
        check_stream("", n);
    endtask

    task automatic test_short(input int n);
        fr[0] = 4'h5;
        fr[1] = 4'h5;
        clear_cap();
        for (int i = 0; i < n; i++) send(1'b1, fr[i]);
        repeat (8) send(1'b0, 4'h0);
        check_stream("R6", n);
    endtask

    task automatic test_col_half();
        full_duplex = 1'b0;
        @(negedge clk);
        tx_en = 1'b1; rx_active = 1'b1;
        @(negedge clk);
        chk("R9", "col both active half", int'(col), 1);
        rx_active = 1'b0;
        @(negedge clk);
        chk("R9", "col tx only", int'(col), 0);
        tx_en = 1'b0; rx_active = 1'b1;
        @(negedge clk);
        chk("R9", "col rx only", int'(col), 0);
        rx_active = 1'b0;
        repeat (8) send(1'b0, 4'h0);
    endtask

    task automatic test_col_full();
        full_duplex = 1'b1;
        @(negedge clk);
        tx_en = 1'b1; rx_active = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10", "col in full duplex", int'(col), 0);
        end
        tx_en = 1'b0; rx_active = 1'b0;
        full_duplex = 1'b0;
        repeat (8) send(1'b0, 4'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        tbl = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        #5;
        test_reset();
        test_tick_period();
        test_idle_toggle();
        test_full_frame();
        test_short(1);
        test_short(2);
        test_col_half();
        test_col_full();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        nchecks++;
        nerr++;
        $display("FAIL watchdog expired got 0 exp 1");
        finish_run();
    end
endmodule